// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block turns single-byte read and write requests from a clocked user port into the strobe sequences that an external static RAM without a clock input needs. The memory is 128K locations of one byte each. The controller drives an address bus, a split data bus (output value, output enable and input value, which the pad ring combines into a tri-state pin), and active-low chip select, output enable and write enable. The strobes always change in a fixed order. Each phase can be stretched by a per-access wait count, so a slow part can be met with extra system clocks. The device sets no upper limit on how long an access may last, so extra cycles do no harm.

The user side uses a request/ready handshake. A request is taken only while the controller is idle. Its address, write data and wait counts are latched at that moment. Read data comes back with a one-cycle valid pulse. For pseudo-static parts that hide a DRAM core, an optional timer forces chip select high for a fixed number of cycles at regular intervals so the part can refresh itself. The forced release is inserted between accesses, and a request that arrives while it is pending waits. At 50 MHz a wait count of zero still gives a full 20 ns strobe, which covers a 15 ns access time.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is active and in every idle cycle, chip select, output enable and write enable are high (1), the bus output enable is low (0) and the read-valid output is low.
- R2: A read holds chip select low for one cycle with output enable high, then holds both low for exactly cfg_rd_wait+1 cycles, then releases both together.
- R3: Read data is sampled from the data input at the clock edge that ends the last output-enable cycle, and is presented in the next cycle together with a read-valid pulse exactly one cycle long.
- R4: A write drives data and chip select for one cycle with write enable high, holds write enable low for exactly cfg_wr_wait+1 cycles, then keeps chip select low and the data driven for one more cycle with write enable high.
- R5: The bus output enable is never high in a cycle where the memory output enable is low.
- R6: The address, and during a write the driven data, equal the values latched at acceptance and stay stable for the whole access.
- R7: Ready is high only in idle cycles that have no refresh pending. A request is taken on a clock edge where both valid and ready are high, and the next cycle starts its access. A request held valid while the controller is busy has no effect on the running access.
- R8: The read and write wait counts are sampled when the request is taken. Later changes of the wait inputs do not alter an access in progress.
- R9: With the refresh option on, once REF_PERIOD cycles have passed since the last forced release, the next idle cycle starts a window of REF_HOLD cycles with chip select high and ready low. The interval between windows of REF_HOLD or more consecutive chip-select-high cycles never exceeds REF_PERIOD plus the longest access plus a small constant.
- R10: Output enable and write enable are never low together, and neither is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| cfg_rd_wait | input | WAIT_W | Extra output-enable cycles for a read |
| cfg_wr_wait | input | WAIT_W | Extra write-enable cycles for a write |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| rd_data | output | DATA_W | Byte returned by the last read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Data read from the data pins |

## Verification
The hardest case to reach is a request that is already waiting when the refresh timer comes due. Only the exact cycle decides whether the request or the forced release goes first. To make this case frequent, the bench shortens the refresh period to a few dozen cycles and issues long runs of back-to-back requests with mixed wait counts and short idle gaps. In that traffic the request valid is high on many of the cycles where refresh becomes due. A behavioural model with its own refresh age counter predicts the expected strobe vector and ready value for every cycle.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int WAIT_W     = 4,
  parameter bit REF_EN     = 1'b1,
  parameter int REF_PERIOD = 700,
  parameter int REF_HOLD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int HOLD_W = $clog2(REF_HOLD + 1);
  localparam int CNT_W  = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;
  localparam int REF_W  = $clog2(REF_PERIOD + 1);
  localparam logic [REF_W-1:0] REF_LIM  = REF_W'(REF_PERIOD);
  localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(REF_HOLD - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_SET, S_RD_OE, S_WR_SET, S_WR_PULSE, S_WR_HOLD, S_REF
  } st_t;

  st_t              state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             ref_due;
  logic             take;
  logic             cnt_zero;
  logic             rd_last;

  assign cnt_zero  = (cnt == '0);
  assign req_ready = (state == S_IDLE) && !ref_due;
  assign take      = req_ready && req_valid;
  assign rd_last   = (state == S_RD_OE) && cnt_zero;

  generate
    if (REF_EN) begin : g_ref
      logic [REF_W-1:0] ref_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ref_cnt <= '0;
        else if (state == S_REF)   ref_cnt <= '0;
        else if (ref_cnt != REF_LIM) ref_cnt <= ref_cnt + 1'b1;
      end
      assign ref_due = (ref_cnt == REF_LIM);
    end else begin : g_noref
      assign ref_due = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      S_IDLE: begin
        if (ref_due) begin
          nxt     = S_REF;
          cnt_nxt = HOLD_CNT;
        end else if (req_valid) begin
          nxt     = req_write ? S_WR_SET : S_RD_SET;
          cnt_nxt = CNT_W'(req_write ? cfg_wr_wait : cfg_rd_wait);
        end
      end
      S_RD_SET:   nxt = S_RD_OE;
      S_RD_OE:    if (cnt_zero) nxt = S_IDLE;    else cnt_nxt = cnt - 1'b1;
      S_WR_SET:   nxt = S_WR_PULSE;
      S_WR_PULSE: if (cnt_zero) nxt = S_WR_HOLD; else cnt_nxt = cnt - 1'b1;
      S_WR_HOLD:  nxt = S_IDLE;
      S_REF:      if (cnt_zero) nxt = S_IDLE;    else cnt_nxt = cnt - 1'b1;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= cnt_nxt;
      mem_cs_n  <= !(nxt inside {S_RD_SET, S_RD_OE, S_WR_SET, S_WR_PULSE, S_WR_HOLD});
      mem_oe_n  <= (nxt != S_RD_OE);
      mem_we_n  <= (nxt != S_WR_PULSE);
      mem_dq_oe <= (nxt inside {S_WR_SET, S_WR_PULSE, S_WR_HOLD});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (take) begin
      mem_addr <= req_addr;
      if (req_write) mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_last;
      if (rd_last) rd_data <= mem_dq_in;
    end
  end
endmodule

module sram_seq_ctrl_chk #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int WAIT_W     = 4,
  parameter bit REF_EN     = 1'b1,
  parameter int REF_PERIOD = 700,
  parameter int REF_HOLD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  localparam int GAP_MAX = REF_PERIOD + (2 ** WAIT_W) + REF_HOLD + 8;

  a_r5_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r10_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);
  a_r2_oe_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_cs_n) && !mem_cs_n);
  a_r4_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n && mem_dq_oe));
  a_r4_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe && !mem_cs_n);
  a_r3_valid_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(mem_oe_n));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n && !mem_dq_oe);
  a_r7_take_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_cs_n);

  generate
    if (REF_EN) begin : g_gap
      int hi_run;
      int gap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_run <= 0;
          gap    <= 0;
        end else begin
          if (!mem_cs_n)              hi_run <= 0;
          else if (hi_run < REF_HOLD) hi_run <= hi_run + 1;
          if (hi_run >= REF_HOLD) gap <= 0;
          else                    gap <= gap + 1;
        end
      end
      a_r9_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GAP_MAX);
    end
  endgenerate
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W),
  .REF_EN(REF_EN), .REF_PERIOD(REF_PERIOD), .REF_HOLD(REF_HOLD)
) chk_i (.*);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int WW = 4;
  localparam int RP = 60;
  localparam int RH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [WW-1:0] cfg_rd_wait = '0, cfg_wr_wait = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  always #10 clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW), .REF_EN(1'b1),
                  .REF_PERIOD(RP), .REF_HOLD(RH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int vectors = 0;
  int miscompares = 0;

  function automatic logic [DW-1:0] seed_val(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
  endfunction

  logic [DW-1:0] dev_mem [int];
  logic [DW-1:0] sb_mem  [int];

  function automatic logic [DW-1:0] dev_rd(logic [AW-1:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : seed_val(a);
  endfunction
  function automatic logic [DW-1:0] sb_rd(logic [AW-1:0] a);
    return sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : seed_val(a);
  endfunction

  task automatic check(string tg, string nm, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tg, nm, act, exp, $time);
    end
  endtask

  // Reference model: bits {refresh, last_read, cs_n, oe_n, we_n, dq_oe}
  logic [5:0]    sched [$];
  int            ref_age;
  logic          exp_rdv;
  logic [DW-1:0] exp_rdata, exp_wdata;
  logic [AW-1:0] exp_addr;
  logic          m_empty, m_ref, m_rdv;

  always @(posedge clk) begin
    if (!rst_n) begin
      sched.delete();
      ref_age = 0;
      exp_rdv = 1'b0;
    end else begin
      m_empty = (sched.size() == 0);
      m_ref   = !m_empty && sched[0][5];
      m_rdv   = !m_empty && sched[0][4];
      if (!m_empty) void'(sched.pop_front());
      else if (ref_age >= RP) begin
        for (int i = 0; i < RH; i++) sched.push_back(6'b101110);
      end else if (req_valid) begin
        exp_addr = req_addr;
        if (req_write) begin
          exp_wdata = req_wdata;
          sb_mem[int'(req_addr)] = req_wdata;
          sched.push_back(6'b000111);
          for (int i = 0; i <= int'(cfg_wr_wait); i++) sched.push_back(6'b000101);
          sched.push_back(6'b000111);
        end else begin
          exp_rdata = sb_rd(req_addr);
          sched.push_back(6'b000110);
          for (int i = 0; i < int'(cfg_rd_wait); i++) sched.push_back(6'b000010);
          sched.push_back(6'b010010);
        end
      end
      ref_age = m_ref ? 0 : ((ref_age < RP) ? ref_age + 1 : RP);
      exp_rdv = m_rdv;
    end
  end

  logic       we_prev = 1'b1;
  logic [5:0] ev;
  string      tg;

  always @(negedge clk) begin
    if (!rst_n) we_prev = 1'b1;
    else begin
      if (!we_prev && mem_we_n && !mem_cs_n) dev_mem[int'(mem_addr)] = mem_dq_out;
      we_prev = mem_we_n;
      mem_dq_in <= (!mem_cs_n && !mem_oe_n) ? dev_rd(mem_addr) : '0;
      if (sched.size() == 0) begin ev = 6'b001110; tg = "R1"; end
      else begin
        ev = sched[0];
        tg = ev[5] ? "R9" : (ev[0] ? "R4" : "R2");
      end
      check(tg, "mem_cs_n", int'(mem_cs_n), int'(ev[3]));
      check(tg, "mem_oe_n", int'(mem_oe_n), int'(ev[2]));
      check(tg, "mem_we_n", int'(mem_we_n), int'(ev[1]));
      check(tg, "mem_dq_oe", int'(mem_dq_oe), int'(ev[0]));
      if (!mem_oe_n) check("R5", "dq_oe during oe", int'(mem_dq_oe), 0);
      check("R10", "oe_we overlap", int'(!mem_oe_n && !mem_we_n), 0);
      check("R7", "req_ready", int'(req_ready), int'(sched.size() == 0 && ref_age < RP));
      check("R3", "rd_valid", int'(rd_valid), int'(exp_rdv));
      if (exp_rdv) check("R3", "rd_data", int'(rd_data), int'(exp_rdata));
      if (!ev[3]) check("R6", "mem_addr", int'(mem_addr), int'(exp_addr));
      if (ev[0])  check("R6", "mem_dq_out", int'(mem_dq_out), int'(exp_wdata));
    end
  end

  task automatic issue(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, int rw, int ww);
    req_valid   = 1'b1;
    req_write   = wr;
    req_addr    = a;
    req_wdata   = d;
    cfg_rd_wait = WW'(rw);
    cfg_wr_wait = WW'(ww);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: strobes parked during reset
    check("R1", "reset cs_n", int'(mem_cs_n), 1);
    check("R1", "reset oe_n", int'(mem_oe_n), 1);
    check("R1", "reset we_n", int'(mem_we_n), 1);
    check("R1", "reset dq_oe", int'(mem_dq_oe), 0);
    check("R1", "reset rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", int'(req_ready), 1);

    // R2, R3: reads of unwritten locations, several wait counts
    issue(1'b0, 17'h00010, 8'h00, 0, 0);
    repeat (3) @(negedge clk);
    issue(1'b0, 17'h1FFFF, 8'h00, 1, 0);
    repeat (4) @(negedge clk);
    issue(1'b0, 17'h0AA55, 8'h00, 3, 0);
    repeat (6) @(negedge clk);
    issue(1'b0, 17'h00000, 8'h00, 15, 0);
    repeat (20) @(negedge clk);

    // R4: writes with different pulse widths, then read back
    issue(1'b1, 17'h00020, 8'hA5, 0, 0);
    issue(1'b1, 17'h1FFFF, 8'h3C, 0, 2);
    issue(1'b1, 17'h00000, 8'hFF, 0, 15);
    issue(1'b0, 17'h00020, 8'h00, 2, 0);
    issue(1'b0, 17'h1FFFF, 8'h00, 0, 0);
    issue(1'b0, 17'h00000, 8'h00, 5, 0);
    repeat (10) @(negedge clk);

    // R8: wait inputs change right after acceptance
    issue(1'b0, 17'h00020, 8'h00, 6, 0);
    cfg_rd_wait = '0;
    cfg_wr_wait = 4'hF;
    repeat (12) @(negedge clk);
    issue(1'b1, 17'h00030, 8'h5A, 0, 1);
    cfg_wr_wait = 4'h9;
    repeat (8) @(negedge clk);

    // R7, R9: back-to-back traffic with requests held while busy and refresh colliding
    for (int k = 0; k < 120; k++) begin
      issue(1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)) | ((k % 3 == 0) ? 17'h1FFF0 : 17'h0),
            DW'($urandom), $urandom_range(0, 4), $urandom_range(0, 4));
      if (k % 7 == 0) repeat (k % 5) @(negedge clk);
    end

    // R9: long idle stretch sees several forced releases
    repeat (200) @(negedge clk);
    finish_run();
  end
endmodule